// File: doc/BRIEF.md
# Gshare Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a global history register, which is a shift register of recent branch outcomes with 1 for taken and 0 for not-taken. It also keeps one shared table of 2-bit saturating counters. The block forms a table index by XORing the history with a slice of the fetch PC. The upper bit of the selected counter gives the guess.

The history cannot wait for branches to resolve, because later branches need it first. So every valid lookup shifts its own guess into the history straight away. Each guess comes with a checkpoint, which is the history as it stood before that branch was shifted in. The checkpoint travels down the pipeline with the branch.

At resolve time the pipeline returns four things: the branch PC, the real outcome, a mispredict flag and the checkpoint. The block rebuilds the original table index from the checkpoint and the PC, and moves that counter one step toward the real outcome. On a mispredict the history is rebuilt from the checkpoint with the real outcome shifted in. A repair in the same cycle as a lookup wins over that lookup's speculative shift.

Top module: `gshp_predictor`

## Requirements
- R1: After reset the history is all zeros and every counter holds weakly-not-taken (01). The first lookup after reset therefore predicts not-taken and returns checkpoint 0.
- R2: When `fetch_valid` is 1, `pred_taken` is in the same cycle the upper bit of the counter at index `fetch_pc[PC_LSB +: HIST_W] ^ history`. Counter values 10 and 11 mean taken.
- R3: When `fetch_valid` is 0, `pred_taken` is 0 (the not-taken default). The history is left unchanged unless a repair occurs.
- R4: `pred_ckpt` shows the history before the current lookup. A valid lookup with no repair in the same cycle makes the next history `{pred_ckpt[HIST_W-2:0], pred_taken}`.
- R5: A resolve selects the counter at index `res_pc[PC_LSB +: HIST_W] ^ res_ckpt`. It adds 1 to that counter for a taken outcome and subtracts 1 for a not-taken outcome. The write is visible to lookups from the next cycle on.
- R6: Counters saturate. A taken resolve leaves 11 at 11, and a not-taken resolve leaves 00 at 00.
- R7: A resolve with `res_mispredict` set makes the next history `{res_ckpt[HIST_W-2:0], res_taken}`. This takes priority over a lookup in the same cycle.
- R8: A resolve without `res_mispredict` leaves the history unchanged.
- R9: A counter in a taken state starting from 11 needs two not-taken resolves before it predicts not-taken. The same holds in the other direction from 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | A branch lookup is requested this cycle |
| fetch_pc | input | PC_W | PC of the branch being looked up |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_ckpt | output | HIST_W | History before this lookup, kept by the pipeline for the branch |
| res_valid | input | 1 | A branch resolves this cycle |
| res_pc | input | PC_W | PC of the resolving branch |
| res_taken | input | 1 | Actual outcome, 1 = taken |
| res_mispredict | input | 1 | The earlier guess for this branch was wrong |
| res_ckpt | input | HIST_W | Checkpoint issued with that branch's guess |

## Verification
The assertions assume the following about the resolve port:
- `res_ckpt` is a value this block issued on `pred_ckpt` earlier.
- `res_mispredict` marks an outcome that differs from the guess made then.
- Any lookup presented in the same cycle as a repair is on a path the pipeline throws away.

The random stimulus keeps to these rules. It keeps a queue of in-flight branches, each holding its PC, checkpoint and guess, and resolves them oldest first. It sets the mispredict flag only when the outcome differs from the queued guess. On a mispredict it flushes all younger entries and does not queue a lookup from that cycle.

// File: rtl/gshp_pkg.sv
package gshp_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_SNT = 2'b00;
    localparam ctr_t CTR_WNT = 2'b01;
    localparam ctr_t CTR_ST  = 2'b11;

    // One saturating step toward the outcome.
    function automatic ctr_t ctr_step(input ctr_t cur, input logic up);
        ctr_t nxt;
        nxt = cur;
        if (up) begin
            if (cur != CTR_ST) nxt = cur + 2'd1;
        end else begin
            if (cur != CTR_SNT) nxt = cur - 2'd1;
        end
        return nxt;
    endfunction

    function automatic logic ctr_says_taken(input ctr_t cur);
        return cur[1];
    endfunction

endpackage

// File: rtl/gshp_index.sv
module gshp_index #(
    parameter int HIST_W = 8,
    parameter int PC_W   = 32,
    parameter int PC_LSB = 2
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [HIST_W-1:0] hist,
    output logic [HIST_W-1:0] idx
);
    localparam int SLICE_TOP = PC_LSB + HIST_W;

    generate
        if (SLICE_TOP > PC_W) begin : g_bad_slice
            initial $display("gshp_index: PC slice exceeds PC width");
        end
    endgenerate

    logic [PC_W-1:0]   pc_shifted;
    logic [HIST_W-1:0] pc_slice;
    logic              unused_pc_bits;

    always_comb begin
        pc_shifted = pc >> PC_LSB;
        pc_slice   = pc_shifted[HIST_W-1:0];
        idx        = pc_slice ^ hist;
    end

    assign unused_pc_bits = ^pc;

endmodule

// File: rtl/gshp_history.sv
module gshp_history #(
    parameter int HIST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spec_en,
    input  logic              spec_bit,
    input  logic              fix_en,
    input  logic [HIST_W-1:0] fix_hist,
    input  logic              fix_bit,
    output logic [HIST_W-1:0] hist
);
    typedef struct packed {
        logic [HIST_W-1:0] ghr;
    } hist_state_t;

    hist_state_t state_d, state_q;
    logic        unused_fix_msb;

    assign unused_fix_msb = fix_hist[HIST_W-1];

    always_comb begin
        state_d = state_q;
        if (fix_en) begin
            state_d.ghr = {fix_hist[HIST_W-2:0], fix_bit};
        end else if (spec_en) begin
            state_d.ghr = {state_q.ghr[HIST_W-2:0], spec_bit};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q.ghr <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign hist = state_q.ghr;

    // R8: with neither a speculative shift nor a repair, the history holds.
    a_r8_hist_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!spec_en && !fix_en) |=> $stable(hist));

endmodule

// File: rtl/gshp_pht.sv
module gshp_pht
    import gshp_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        ctr_t [DEPTH-1:0] ent;
    } pht_state_t;

    pht_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d.ent[wr_idx] = ctr_step(state_q.ent[wr_idx], wr_up);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                state_q.ent[i] <= CTR_WNT;
            end
        end else begin
            state_q <= state_d;
        end
    end

    assign rd_ctr = state_q.ent[rd_idx];

    // R6: a saturated counter stays put when pushed further the same way.
    a_r6_no_wrap_high: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_up && state_q.ent[wr_idx] == CTR_ST)
        |=> state_q.ent[$past(wr_idx)] == CTR_ST);

    a_r6_no_wrap_low: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_up && state_q.ent[wr_idx] == CTR_SNT)
        |=> state_q.ent[$past(wr_idx)] == CTR_SNT);

    // R5: a non-saturated counter moves exactly one step.
    a_r5_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_up && state_q.ent[wr_idx] != CTR_ST)
        |=> state_q.ent[$past(wr_idx)] == $past(state_q.ent[wr_idx]) + 2'd1);

    a_r5_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_up && state_q.ent[wr_idx] != CTR_SNT)
        |=> state_q.ent[$past(wr_idx)] == $past(state_q.ent[wr_idx]) - 2'd1);

endmodule

// File: rtl/gshp_predictor.sv
module gshp_predictor
    import gshp_pkg::*;
#(
    parameter int HIST_W = 8,
    parameter int PC_W   = 32,
    parameter int PC_LSB = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_valid,
    input  logic [PC_W-1:0]   fetch_pc,
    output logic              pred_taken,
    output logic [HIST_W-1:0] pred_ckpt,
    input  logic              res_valid,
    input  logic [PC_W-1:0]   res_pc,
    input  logic              res_taken,
    input  logic              res_mispredict,
    input  logic [HIST_W-1:0] res_ckpt
);
    logic [HIST_W-1:0] hist;
    logic [HIST_W-1:0] fetch_idx;
    logic [HIST_W-1:0] res_idx;
    ctr_t              fetch_ctr;
    logic              repair;

    assign repair = res_valid && res_mispredict;

    // Lookup index uses the live history.
    gshp_index #(.HIST_W(HIST_W), .PC_W(PC_W), .PC_LSB(PC_LSB)) u_fetch_idx (
        .pc   (fetch_pc),
        .hist (hist),
        .idx  (fetch_idx)
    );

    // Resolve index is rebuilt from the branch's own checkpoint.
    gshp_index #(.HIST_W(HIST_W), .PC_W(PC_W), .PC_LSB(PC_LSB)) u_res_idx (
        .pc   (res_pc),
        .hist (res_ckpt),
        .idx  (res_idx)
    );

    gshp_pht #(.IDX_W(HIST_W)) u_pht (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_idx (fetch_idx),
        .rd_ctr (fetch_ctr),
        .wr_en  (res_valid),
        .wr_idx (res_idx),
        .wr_up  (res_taken)
    );

    always_comb begin
        pred_taken = fetch_valid && ctr_says_taken(fetch_ctr);
        pred_ckpt  = hist;
    end

    gshp_history #(.HIST_W(HIST_W)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .spec_en  (fetch_valid),
        .spec_bit (pred_taken),
        .fix_en   (repair),
        .fix_hist (res_ckpt),
        .fix_bit  (res_taken),
        .hist     (hist)
    );

    // R4: a lookup with no repair shifts its own guess into the history.
    a_r4_spec_shift: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && !repair)
        |=> pred_ckpt == {$past(pred_ckpt[HIST_W-2:0]), $past(pred_taken)});

    // R7: a repair rebuilds the history from the checkpoint and outcome.
    a_r7_repair: assert property (@(posedge clk) disable iff (!rst_n)
        repair |=> pred_ckpt == {$past(res_ckpt[HIST_W-2:0]), $past(res_taken)});

    // R3: with no lookup and no repair, the checkpoint output holds.
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!fetch_valid && !repair) |=> $stable(pred_ckpt));

endmodule

// File: tb/gshp_predictor_test.sv
module gshp_predictor_test;
    localparam int HW    = 8;
    localparam int PCW   = 32;
    localparam int LSB   = 2;
    localparam int DEPTH = 1 << HW;
    localparam int MASK  = DEPTH - 1;

    logic           clk;
    logic           rst_n;
    logic           fetch_valid;
    logic [PCW-1:0] fetch_pc;
    logic           pred_taken;
    logic [HW-1:0]  pred_ckpt;
    logic           res_valid;
    logic [PCW-1:0] res_pc;
    logic           res_taken;
    logic           res_mispredict;
    logic [HW-1:0]  res_ckpt;

    gshp_predictor #(.HIST_W(HW), .PC_W(PCW), .PC_LSB(LSB)) uut (
        .clk(clk), .rst_n(rst_n),
        .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
        .pred_taken(pred_taken), .pred_ckpt(pred_ckpt),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
        .res_mispredict(res_mispredict), .res_ckpt(res_ckpt)
    );

    initial clk = 1'b0;
    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;

    // Behavioural reference state.
    int m_hist;
    int m_pht[DEPTH];

    typedef struct {
        int           slot;
        logic [31:0]  pc;
        logic [HW-1:0] ck;
        logic         pr;
    } inflight_t;

    inflight_t flight[$];

    task automatic check_val(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, compare outputs, advance the model.
    task automatic step(input string tag, input logic lv, input logic [31:0] lpc,
                        input logic rv, input logic [31:0] rpc, input logic rt,
                        input logic rm, input logic [HW-1:0] rck,
                        output logic et, output logic [HW-1:0] eck);
        int il, ir, c;
        @(negedge clk);
        fetch_valid    = lv;
        fetch_pc       = lpc;
        res_valid      = rv;
        res_pc         = rpc;
        res_taken      = rt;
        res_mispredict = rm;
        res_ckpt       = rck;
        #1;
        il  = ((int'(lpc) >>> LSB) & MASK) ^ m_hist;
        et  = lv ? (m_pht[il] >= 2) : 1'b0;
        eck = HW'(m_hist);
        check_val(tag, "pred_taken", int'(pred_taken), int'(et));
        check_val(tag, "pred_ckpt", int'(pred_ckpt), int'(eck));
        if (rv) begin
            ir = ((int'(rpc) >>> LSB) & MASK) ^ int'(rck);
            c  = m_pht[ir];
            if (rt) c = (c < 3) ? c + 1 : 3;
            else    c = (c > 0) ? c - 1 : 0;
            m_pht[ir] = c;
        end
        if (rv && rm) m_hist = ((int'(rck) << 1) | int'(rt)) & MASK;
        else if (lv)  m_hist = ((m_hist << 1) | int'(et)) & MASK;
    endtask

    task automatic idle();
        logic t;
        logic [HW-1:0] k;
        step("R3", 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b0, '0, t, k);
    endtask

    task automatic resolve_only(input string tag, input logic [31:0] pc, input logic tk,
                                input logic mp, input logic [HW-1:0] ck);
        logic t;
        logic [HW-1:0] k;
        step(tag, 1'b0, 32'h0, 1'b1, pc, tk, mp, ck, t, k);
    endtask

    task automatic lookup(input string tag, input logic [31:0] pc, output logic t);
        logic [HW-1:0] k;
        step(tag, 1'b1, pc, 1'b0, 32'h0, 1'b0, 1'b0, '0, t, k);
    endtask

    // Set the history to zero through a repair (R7).
    task automatic zero_hist();
        resolve_only("R7", 32'hFFFF_FF00, 1'b0, 1'b1, '0);
        m_pht[0] = m_pht[0];
    endtask

    localparam logic [31:0] PB = 32'h0000_0340;

    initial begin
        logic t;
        logic [HW-1:0] k;
        rst_n = 1'b0;
        fetch_valid = 0; fetch_pc = 0; res_valid = 0; res_pc = 0;
        res_taken = 0; res_mispredict = 0; res_ckpt = 0;
        m_hist = 0;
        for (int i = 0; i < DEPTH; i++) m_pht[i] = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state seen through the first lookup.
        step("R1", 1'b1, 32'h0000_1234, 1'b0, 32'h0, 1'b0, 1'b0, '0, t, k);
        check_val("R1", "first guess", int'(t), 0);

        // R3: no lookup gives not-taken and keeps the history.
        idle(); idle(); idle();
        lookup("R3", 32'h0000_0040, t);

        // R5: one taken resolve turns 01 into 10.
        zero_hist();
        resolve_only("R5", PB, 1'b1, 1'b0, '0);
        lookup("R5", PB, t);
        check_val("R5", "after one taken", int'(t), 1);

        // R7: repair after the taken guess shifted a 1 in.
        zero_hist();
        lookup("R7", PB, t);

        // R6: push to 11 and beyond, then R9 hysteresis.
        zero_hist();
        repeat (4) resolve_only("R6", PB, 1'b1, 1'b0, '0);
        lookup("R6", PB, t);
        check_val("R6", "saturated high", int'(t), 1);
        zero_hist();
        resolve_only("R9", PB, 1'b0, 1'b0, '0);
        lookup("R9", PB, t);
        check_val("R9", "one wrong from strong", int'(t), 1);
        zero_hist();
        resolve_only("R9", PB, 1'b0, 1'b0, '0);
        lookup("R9", PB, t);
        check_val("R9", "two wrong from strong", int'(t), 0);
        zero_hist();
        repeat (5) resolve_only("R6", PB, 1'b0, 1'b0, '0);
        resolve_only("R6", PB, 1'b1, 1'b0, '0);
        lookup("R6", PB, t);
        check_val("R6", "no wrap low", int'(t), 0);

        // R8: correct resolve leaves history alone.
        resolve_only("R7", PB, 1'b1, 1'b1, 8'hA5);
        resolve_only("R8", PB, 1'b1, 1'b0, 8'h3C);
        lookup("R8", 32'h0000_0080, t);

        // R7: repair beats a same-cycle lookup.
        step("R7", 1'b1, PB, 1'b1, 32'h0000_0200, 1'b1, 1'b1, 8'h81, t, k);
        lookup("R7", PB, t);

        // R2: random stream of in-flight branches resolved oldest first.
        zero_hist();
        flight.delete();
        for (int cyc = 0; cyc < 4000; cyc++) begin
            logic lv, rv, rt, rm;
            logic [31:0] lpc, rpc;
            logic [HW-1:0] rck;
            int slot;
            inflight_t e;
            slot = int'($urandom_range(0, 5));
            lv   = ($urandom_range(0, 9) < 7);
            lpc  = 32'h0000_2000 + 32'(slot * 36);
            rv = 1'b0; rt = 1'b0; rm = 1'b0; rpc = '0; rck = '0;
            if (flight.size() > 0 && $urandom_range(0, 1) == 1) begin
                e = flight.pop_front();
                rv  = 1'b1;
                rpc = e.pc;
                rck = e.ck;
                case (e.slot)
                    0: rt = 1'b1;
                    1: rt = 1'b0;
                    2: rt = (cyc % 3) != 0;
                    default: rt = 1'($urandom_range(0, 1));
                endcase
                rm = (rt != e.pr);
            end
            step("R2", lv, lpc, rv, rpc, rt, rm, rck, t, k);
            if (rv && rm) begin
                flight.delete();
            end else if (lv) begin
                e.slot = slot; e.pc = lpc; e.ck = k; e.pr = t;
                flight.push_back(e);
            end
        end

        @(negedge clk);
        fetch_valid = 0; res_valid = 0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 20);
        errors++;
        $display("FAIL watchdog all requirements actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule